// File: doc/BRIEF.md
# Multiply and Range-Folding Divide Unit

This unit runs one of two fixed-latency arithmetic operations on an 8-bit accumulator pair and an 8-bit index operand. The pair is formed from a high byte Y and a low byte A, and the index operand is X. A multiply replaces the pair with the 16-bit product of Y and A. A divide replaces A with a quotient and Y with a remainder taken from the 16-bit pair YA and X. The divide never traps. When the true quotient would not fit, it gives a defined, non-saturating result. A zero divisor is handled by that same rule.

The surrounding datapath pulses a start strobe with an operation select and the three operands. It then waits for a one-cycle done pulse. At that pulse the new A, the new Y and four condition flags (negative, zero, overflow, half) are valid. Those outputs are registered and stay unchanged until the next operation completes. The latency is fixed for each operation, so a sequencer can schedule around the unit without a handshake.

Top module: `muldiv_unit`

## Requirements
- R1: A multiply (op_div_i = 0) sets a_o to the low byte and y_o to the high byte of the 16-bit unsigned product y_i * a_i.
- R2: After a multiply, flag_n_o equals bit 15 of the product and flag_z_o is 1 exactly when the product is zero. flag_v_o and flag_h_o keep their previous values.
- R3: A divide (op_div_i = 1) sets flag_h_o when y_i[3:0] >= x_i[3:0] and sets flag_v_o when y_i >= x_i, both compared unsigned. Otherwise each of the two flags is cleared.
- R4: For a divide with y_i < 2*x_i, a_o is the low 8 bits of {y_i,a_i} / x_i and y_o is {y_i,a_i} mod x_i.
- R5: For a divide with y_i >= 2*x_i, let D = {y_i,a_i} - 512*x_i and M = 256 - x_i. Then a_o = (255 - D/M) mod 256 and y_o = (x_i + D mod M) mod 256.
- R6: A divide with x_i = 0 follows R5 with M = 256 and completes normally, with no error indication.
- R7: After a divide, flag_n_o equals bit 7 of the new a_o and flag_z_o is 1 exactly when the new a_o is zero.
- R8: If a multiply start is sampled at rising edge t, done_o is high in the cycle that follows edge t+8, so the multiply spans 9 cycles.
- R9: If a divide start is sampled at rising edge t, done_o is high in the cycle that follows edge t+11, so the divide spans 12 cycles.
- R10: done_o is high for exactly one cycle per accepted start. a_o, y_o and the four flags change only at the edge that raises done_o and hold their values otherwise.
- R11: A start that is high while an operation is in progress is ignored, including during the done cycle. It produces no done pulse and does not alter the results.
- R12: Synchronous active-high reset clears a_o, y_o, all flags and done_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled when idle |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| y_i | input | 8 | High byte of the pair operand |
| a_i | input | 8 | Low byte of the pair operand |
| x_i | input | 8 | Divisor operand (unused by multiply) |
| a_o | output | 8 | New low byte result |
| y_o | output | 8 | New high byte result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_h_o | output | 1 | Half flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every internal fault in this unit becomes visible at the next done pulse, at most 12 cycles after the start is accepted. Several kinds of fault can show there. A wrong remainder or quotient register shows up as a bad a_o or y_o. A wrong range-select decision latched at load corrupts both bytes in a recognisable way, because quotient bits are inverted and X is added to the remainder. A miscounting sequencer moves the done pulse off its fixed cycle, or duplicates it. A busy state that is stuck or cleared early shows up as a missing done, or as a spurious result after an ignored start.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

    localparam int unsigned MD_W       = 8;
    localparam int unsigned MD_MUL_LAT = 9;
    localparam int unsigned MD_DIV_LAT = 12;
    localparam int unsigned MD_STEPS   = 2;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic h;
    } md_flags_t;

    function automatic int unsigned md_iters(input int unsigned bits, input int unsigned steps);
        return (bits + steps - 1) / steps;
    endfunction

endpackage

// File: rtl/md_seq.sv
`timescale 1ns/1ps
module md_seq
    import muldiv_pkg::*;
#(
    parameter int unsigned MUL_LAT   = MD_MUL_LAT,
    parameter int unsigned DIV_LAT   = MD_DIV_LAT,
    parameter int unsigned MUL_ITERS = 4,
    parameter int unsigned DIV_ITERS = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  md_op_e op_i,
    output logic   load_o,
    output logic   step_o,
    output logic   capture_o,
    output logic   done_o,
    output md_op_e op_o
);
    localparam int unsigned MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
    localparam int unsigned CW      = $clog2(MAX_LAT + 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    md_op_e        op_q;
    logic [CW-1:0] cap_at;
    logic [CW-1:0] iter_lim;

    always_comb begin
        cap_at   = (op_q == OP_DIV) ? CW'(DIV_LAT - 2)  : CW'(MUL_LAT - 2);
        iter_lim = (op_q == OP_DIV) ? CW'(DIV_ITERS)    : CW'(MUL_ITERS);
    end

    assign load_o    = start_i && !busy_q;
    assign step_o    = busy_q && (cnt_q < iter_lim);
    assign capture_o = busy_q && !done_q && (cnt_q == cap_at);
    assign done_o    = done_q;
    assign op_o      = op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_MUL;
        end else begin
            done_q <= capture_o;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                op_q   <= op_i;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (done_q) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/md_mul_engine.sv
`timescale 1ns/1ps
module md_mul_engine #(
    parameter int unsigned W     = 8,
    parameter int unsigned STEPS = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   y_i,
    input  logic [W-1:0]   a_i,
    output logic [2*W-1:0] prod_o
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] acc_q, mcand_q;
    logic [W-1:0]  mplier_q;

    logic [PW-1:0] acc_c   [0:STEPS];
    logic [PW-1:0] mcand_c [0:STEPS];
    logic [W-1:0]  mplier_c[0:STEPS];

    assign acc_c[0]    = acc_q;
    assign mcand_c[0]  = mcand_q;
    assign mplier_c[0] = mplier_q;

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        assign acc_c[s+1]    = mplier_c[s][0] ? (acc_c[s] + mcand_c[s]) : acc_c[s];
        assign mcand_c[s+1]  = {mcand_c[s][PW-2:0], 1'b0};
        assign mplier_c[s+1] = {1'b0, mplier_c[s][W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load_i) begin
            acc_q    <= '0;
            mcand_q  <= {{W{1'b0}}, y_i};
            mplier_q <= a_i;
        end else if (step_i) begin
            acc_q    <= acc_c[STEPS];
            mcand_q  <= mcand_c[STEPS];
            mplier_q <= mplier_c[STEPS];
        end
    end

    assign prod_o = acc_q;
endmodule

// File: rtl/md_div_engine.sv
`timescale 1ns/1ps
module md_div_engine #(
    parameter int unsigned W     = 8,
    parameter int unsigned STEPS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] a_res_o,
    output logic [W-1:0] y_res_o,
    output logic         h_o,
    output logic         v_o
);
    localparam int unsigned DW = 2 * W;
    localparam int unsigned NB = W / 2;

    logic [DW-1:0] quo_q;
    logic [W:0]    rem_q;
    logic [W:0]    dvs_q;
    logic [W-1:0]  x_q;
    logic          fold_q, h_q, v_q;

    // operand remapping at load
    logic          fold_ld;
    logic [DW-1:0] ya_ld;
    logic [DW:0]   shifted_x;
    logic [DW:0]   diff_ld;
    logic [DW-1:0] dvd_ld;
    logic [W:0]    dvs_ld;

    always_comb begin
        ya_ld     = {y_i, a_i};
        fold_ld   = ({1'b0, y_i} >= {x_i, 1'b0});
        shifted_x = {x_i, {(W+1){1'b0}}};
        diff_ld   = {1'b0, ya_ld} - shifted_x;
        dvd_ld    = fold_ld ? diff_ld[DW-1:0] : ya_ld;
        dvs_ld    = fold_ld ? ({1'b1, {W{1'b0}}} - {1'b0, x_i}) : {1'b0, x_i};
    end

    // restoring division chain, STEPS bits per cycle
    logic [DW-1:0] quo_c[0:STEPS];
    logic [W:0]    rem_c[0:STEPS];

    assign quo_c[0] = quo_q;
    assign rem_c[0] = rem_q;

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        logic [W+1:0] trial;
        logic         fits;
        logic [W:0]   sub;
        assign trial      = {rem_c[s], quo_c[s][DW-1]};
        assign fits       = (trial >= {1'b0, dvs_q});
        assign sub        = trial[W:0] - dvs_q;
        assign rem_c[s+1] = fits ? sub : trial[W:0];
        assign quo_c[s+1] = {quo_c[s][DW-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            x_q    <= '0;
            fold_q <= 1'b0;
            h_q    <= 1'b0;
            v_q    <= 1'b0;
        end else if (load_i) begin
            quo_q  <= dvd_ld;
            rem_q  <= '0;
            dvs_q  <= dvs_ld;
            x_q    <= x_i;
            fold_q <= fold_ld;
            h_q    <= (y_i[NB-1:0] >= x_i[NB-1:0]);
            v_q    <= (y_i >= x_i);
        end else if (step_i) begin
            quo_q <= quo_c[STEPS];
            rem_q <= rem_c[STEPS];
        end
    end

    // folded range: quotient bits inverted, X added to the remainder
    always_comb begin
        if (fold_q) begin
            a_res_o = ~quo_q[W-1:0];
            y_res_o = x_q + rem_q[W-1:0];
        end else begin
            a_res_o = quo_q[W-1:0];
            y_res_o = rem_q[W-1:0];
        end
    end

    assign h_o = h_q;
    assign v_o = v_q;

    logic unused_ok;
    assign unused_ok = ^{quo_q[DW-1:W], rem_q[W]};
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int unsigned W       = MD_W,
    parameter int unsigned MUL_LAT = MD_MUL_LAT,
    parameter int unsigned DIV_LAT = MD_DIV_LAT,
    parameter int unsigned STEPS   = MD_STEPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         op_div_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] y_o,
    output logic         flag_n_o,
    output logic         flag_z_o,
    output logic         flag_v_o,
    output logic         flag_h_o,
    output logic         done_o
);
    localparam int unsigned MUL_ITERS = md_iters(W, STEPS);
    localparam int unsigned DIV_ITERS = md_iters(2 * W, STEPS);

    logic          load, step, capture;
    md_op_e        op_run;
    logic [2*W-1:0] prod;
    logic [W-1:0]  div_a, div_y;
    logic          div_h, div_v;

    md_seq #(
        .MUL_LAT  (MUL_LAT),
        .DIV_LAT  (DIV_LAT),
        .MUL_ITERS(MUL_ITERS),
        .DIV_ITERS(DIV_ITERS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (op_div_i ? OP_DIV : OP_MUL),
        .load_o   (load),
        .step_o   (step),
        .capture_o(capture),
        .done_o   (done_o),
        .op_o     (op_run)
    );

    md_mul_engine #(.W(W), .STEPS(STEPS)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .load_i(load),
        .step_i(step && (op_run == OP_MUL)),
        .y_i   (y_i),
        .a_i   (a_i),
        .prod_o(prod)
    );

    md_div_engine #(.W(W), .STEPS(STEPS)) u_div (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .step_i (step && (op_run == OP_DIV)),
        .y_i    (y_i),
        .a_i    (a_i),
        .x_i    (x_i),
        .a_res_o(div_a),
        .y_res_o(div_y),
        .h_o    (div_h),
        .v_o    (div_v)
    );

    logic [W-1:0] a_q, y_q;
    md_flags_t    flags_q, flags_d;
    logic [W-1:0] a_d, y_d;

    always_comb begin
        flags_d = flags_q;
        if (op_run == OP_DIV) begin
            a_d       = div_a;
            y_d       = div_y;
            flags_d.n = div_a[W-1];
            flags_d.z = (div_a == '0);
            flags_d.v = div_v;
            flags_d.h = div_h;
        end else begin
            a_d       = prod[W-1:0];
            y_d       = prod[2*W-1:W];
            flags_d.n = prod[2*W-1];
            flags_d.z = (prod == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            y_q     <= '0;
            flags_q <= '0;
        end else if (capture) begin
            a_q     <= a_d;
            y_q     <= y_d;
            flags_q <= flags_d;
        end
    end

    assign a_o      = a_q;
    assign y_o      = y_q;
    assign flag_n_o = flags_q.n;
    assign flag_z_o = flags_q.z;
    assign flag_v_o = flags_q.v;
    assign flag_h_o = flags_q.h;
endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk #(
    parameter int unsigned W       = 8,
    parameter int unsigned MUL_LAT = 9,
    parameter int unsigned DIV_LAT = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         op_div_i,
    input logic [W-1:0] y_i,
    input logic [W-1:0] x_i,
    input logic [W-1:0] a_o,
    input logic [W-1:0] y_o,
    input logic         flag_n_o,
    input logic         flag_z_o,
    input logic         flag_v_o,
    input logic         flag_h_o,
    input logic         done_o
);
    logic         ck_busy, ck_div;
    logic [7:0]   ck_cnt;
    logic [W-1:0] ck_y, ck_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_busy <= 1'b0;
            ck_div  <= 1'b0;
            ck_cnt  <= '0;
            ck_y    <= '0;
            ck_x    <= '0;
        end else if (start_i && !ck_busy) begin
            ck_busy <= 1'b1;
            ck_div  <= op_div_i;
            ck_cnt  <= '0;
            ck_y    <= y_i;
            ck_x    <= x_i;
        end else if (ck_busy) begin
            ck_cnt <= ck_cnt + 1'b1;
            if (done_o) ck_busy <= 1'b0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(a_o) && $stable(y_o) && $stable(flag_v_o) && $stable(flag_h_o)); // R10
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ck_busy); // R11
    AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o && !ck_div |-> ck_cnt == 8'(MUL_LAT - 1)); // R8
    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o && ck_div |-> ck_cnt == 8'(DIV_LAT - 1)); // R9
    AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done_o && !ck_div |-> (flag_n_o == y_o[W-1]) && (flag_z_o == ({y_o, a_o} == '0))
                              && $stable(flag_v_o) && $stable(flag_h_o)); // R2
    AST_DIV_NZ: assert property (@(posedge clk) disable iff (rst)
        done_o && ck_div |-> (flag_n_o == a_o[W-1]) && (flag_z_o == (a_o == '0))); // R7
    AST_DIV_VFLAG: assert property (@(posedge clk) disable iff (rst)
        done_o && ck_div |-> flag_v_o == (ck_y >= ck_x)); // R3
    AST_DIV_REM_RANGE: assert property (@(posedge clk) disable iff (rst)
        done_o && ck_div && ({1'b0, ck_y} < {ck_x, 1'b0}) |-> y_o < ck_x); // R4
endmodule

bind muldiv_unit muldiv_unit_chk #(
    .W      (W),
    .MUL_LAT(MUL_LAT),
    .DIV_LAT(DIV_LAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .op_div_i(op_div_i),
    .y_i     (y_i),
    .x_i     (x_i),
    .a_o     (a_o),
    .y_o     (y_o),
    .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o),
    .flag_h_o(flag_h_o),
    .done_o  (done_o)
);

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;
    localparam int MUL_LAT = 9;
    localparam int DIV_LAT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       op_div_i = 1'b0;
    logic [7:0] y_i = '0, a_i = '0, x_i = '0;
    logic [7:0] a_o, y_o;
    logic       flag_n_o, flag_z_o, flag_v_o, flag_h_o, done_o;

    always #2 clk = ~clk;

    muldiv_unit u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_div_i(op_div_i),
        .y_i(y_i), .a_i(a_i), .x_i(x_i),
        .a_o(a_o), .y_o(y_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_h_o(flag_h_o),
        .done_o(done_o)
    );

    typedef struct {
        int    a, y, n, z, v, h;
        int    cyc;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0;
    int   cyc = 0;
    int   mv = 0, mh = 0;
    int   last_a = 0, last_y = 0, last_n = 0, last_z = 0;
    bit   prev_done = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: starts one operation and pushes its expected result
    task automatic issue(input bit div, input int y, input int a, input int x, input string req);
        exp_t e;
        int   ya, d, m;
        ya = y * 256 + a;
        if (!div) begin
            e.a = ya == 0 ? 0 : (y * a) % 256;
            e.a = (y * a) % 256;
            e.y = (y * a) / 256;
            e.n = ((y * a) >> 15) & 1;
            e.z = ((y * a) == 0);
            e.v = mv; e.h = mh;
        end else begin
            e.h = ((y % 16) >= (x % 16));
            e.v = (y >= x);
            if (y < 2 * x) begin
                e.a = (ya / x) % 256;
                e.y = (ya % x) % 256;
            end else begin
                d = ya - 512 * x;
                m = 256 - x;
                e.a = (255 - (d / m)) & 255;
                e.y = (x + (d % m)) % 256;
            end
            e.n = (e.a >> 7) & 1;
            e.z = (e.a == 0);
            mv = e.v; mh = e.h;
        end
        e.cyc = cyc + (div ? DIV_LAT : MUL_LAT);
        e.req = req;
        q.push_back(e);
        start_i = 1'b1; op_div_i = div;
        y_i = 8'(y); a_i = 8'(a); x_i = 8'(x);
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    // monitor: pops and compares on every done
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                chk(!prev_done, "R10", "done longer than one cycle", 1, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R11", "done without accepted start", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.cyc, e.req, "done cycle (R8/R9 latency)", cyc, e.cyc);
                    chk(a_o == e.a, e.req, "a_o", a_o, e.a);
                    chk(y_o == e.y, e.req, "y_o", y_o, e.y);
                    chk(flag_n_o == e.n, e.req, "flag_n", flag_n_o, e.n);
                    chk(flag_z_o == e.z, e.req, "flag_z", flag_z_o, e.z);
                    chk(flag_v_o == e.v, e.req, "flag_v", flag_v_o, e.v);
                    chk(flag_h_o == e.h, e.req, "flag_h", flag_h_o, e.h);
                    last_a = e.a; last_y = e.y; last_n = e.n; last_z = e.z;
                end
            end
            prev_done <= done_o;
        end
    end

    task automatic check_hold(input string req);
        chk(done_o == 0, req, "done low between ops", done_o, 0);
        chk(a_o == last_a, req, "a_o held", a_o, last_a);
        chk(y_o == last_y, req, "y_o held", y_o, last_y);
        chk(flag_n_o == last_n && flag_z_o == last_z, req, "n/z held",
            {flag_n_o, flag_z_o}, (last_n << 1) | last_z);
        chk(flag_v_o == mv && flag_h_o == mh, req, "v/h held",
            {flag_v_o, flag_h_o}, (mv << 1) | mh);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(a_o == 0 && y_o == 0, "R12", "results after reset", {y_o, a_o}, 0);
        chk({flag_n_o, flag_z_o, flag_v_o, flag_h_o} == 0, "R12", "flags after reset",
            {flag_n_o, flag_z_o, flag_v_o, flag_h_o}, 0);
        chk(done_o == 0, "R12", "done after reset", done_o, 0);
        @(posedge clk); #1;

        // R1 R2 R8: multiplies
        issue(0, 8'h12, 8'h34, 8'h00, "R1"); wait_idle();
        issue(0, 8'hFF, 8'hFF, 8'h00, "R2"); wait_idle();
        issue(0, 8'h00, 8'h55, 8'h10, "R2"); wait_idle();
        issue(0, 8'h80, 8'h01, 8'h00, "R8"); wait_idle();
        // R4: normal-range divide, including quotient above 255
        issue(1, 8'h12, 8'h34, 8'h56, "R4"); wait_idle();
        issue(1, 8'h50, 8'hFF, 8'h30, "R4"); wait_idle();
        issue(1, 8'h00, 8'h07, 8'h07, "R7"); wait_idle();
        // R3 R2: flags from a divide, then a multiply must keep V/H
        issue(1, 8'h3F, 8'h00, 8'h20, "R3"); wait_idle();
        issue(0, 8'h03, 8'h05, 8'h00, "R2"); wait_idle();
        // R5: folded range
        issue(1, 8'hF0, 8'h00, 8'h10, "R5"); wait_idle();
        issue(1, 8'hFF, 8'hFF, 8'h7F, "R5"); wait_idle();
        issue(1, 8'h02, 8'h00, 8'h01, "R5"); wait_idle();
        // R6: divide by zero
        issue(1, 8'h12, 8'h34, 8'h00, "R6"); wait_idle();
        issue(1, 8'h00, 8'h00, 8'h00, "R6"); wait_idle();
        // R9: divide latency on a fresh pattern
        issue(1, 8'h7F, 8'h80, 8'hC0, "R9"); wait_idle();

        // R10: outputs hold after done
        repeat (5) @(posedge clk);
        #1;
        @(negedge clk);
        check_hold("R10");
        @(posedge clk); #1;

        // R11: start during busy is ignored
        issue(1, 8'h40, 8'h00, 8'h03, "R11");
        repeat (3) @(posedge clk);
        #1 start_i = 1'b1; op_div_i = 1'b0; y_i = 8'hAA; a_i = 8'hBB; x_i = 8'h01;
        @(posedge clk); #1 start_i = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check_hold("R11");
        @(posedge clk); #1;

        // R11: start during the done cycle is ignored
        issue(0, 8'h21, 8'h43, 8'h00, "R11");
        repeat (MUL_LAT - 1) @(posedge clk);
        #1 start_i = 1'b1; op_div_i = 1'b1; y_i = 8'h11; a_i = 8'h22; x_i = 8'h05;
        @(posedge clk); #1 start_i = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check_hold("R11");
        @(posedge clk); #1;

        // mixed pseudo-random patterns across R1 R4 R5 R6
        seed = 32'h1234_5678;
        for (int i = 0; i < 60; i++) begin
            int r;
            seed = seed * 1103515245 + 12345;
            r = int'(seed >> 8);
            if (i % 2 == 0)
                issue(0, (r >> 16) & 255, (r >> 8) & 255, r & 255, "R1");
            else
                issue(1, (r >> 16) & 255, (r >> 8) & 255, (i % 7 == 1) ? 0 : (r & 255),
                      ((r >> 16) & 255) < 2 * (r & 255) ? "R4" : "R5");
            wait_idle();
        end

        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R10", "all expected results seen", q.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule